// File: doc/BRIEF.md
# Prefixed Bit-Instruction Sequencer

This block runs the two-byte bit-manipulation instructions of a small 8-bit CPU core. It watches the opcode fetch input while idle. When it sees the prefix byte 0xCB, it reads the second byte from memory at the program counter and advances the counter. It then decodes the byte into an operation group, a bit index or shift kind, and an operand slot.

A register operand is taken from an internal eight-slot register file. The memory operand is read from the address formed by the H and L registers. In both cases the operand goes through a combinational bit/shift unit. The result is written back in the last cycle of a fixed cycle budget, and the flags are updated in that same cycle. A one-cycle done strobe marks that last cycle.

Reset clears the program counter, every register and the flags, so the surrounding core builds any operand values with the block's own set-bit and clear-bit instructions. Memory sits outside the block behind a simple synchronous port. Read data returns in the cycle after the read strobe.

Top module: `pfx_seq`

## Requirements
- R1: After reset, `pc` is 0, all of `reg_view` is 0, `flags` is 0, and `done`, `mem_rd` and `mem_wr` are low.
- R2: A sequence starts only when the block is idle and `fetch_valid` is high with `fetch_byte` equal to 0xCB. Any other byte, and any byte offered while a sequence is running (including in its done cycle), causes no memory access and leaves `pc` unchanged.
- R3: In the first busy cycle the block reads memory at `pc`, and `pc` advances by exactly one at the end of that cycle.
- R4: Bits 2:0 of the second byte pick the operand: values 0 to 5 and 7 are register slots B, C, D, E, H, L, A. The value of each slot equals its field value, and slot i is shown at `reg_view[8i+7:8i]`. Value 6 selects memory at address {H,L}, and slot 6 of the register file is never written.
- R5: Second-byte values 0x00 to 0x3F are shift group operations. Bits 5:3 pick the operation:
  - 0: rotate left, carry = old bit 7.
  - 1: rotate right, carry = old bit 0.
  - 2: rotate left through carry.
  - 3: rotate right through carry.
  - 4: shift left with a zero in.
  - 5: shift right keeping bit 7.
  - 6: nibble swap, carry = 0.
  - 7: shift right with a zero in.

  Flags are `{Z,N,H,C}` on bits 3..0. After a shift, Z is set when the result is zero, N = 0 and H = 0.
- R6: Values 0x40 to 0x7F test bit (bits 5:3) of the operand. Z is set when that bit is 0, N = 0, H = 1, and C is unchanged. Nothing is written back, neither to a register nor to memory.
- R7: Values 0x80 to 0xBF clear, and 0xC0 to 0xFF set, bit (bits 5:3) of the operand. They write the result back and leave `flags` unchanged.
- R8: `done` is high for exactly one cycle. For a register operand it is the 8th busy cycle, and for the memory operand it is the 16th, counting the fetch cycle as the first.
- R9: For the memory operand, the byte at {H,L} is read. Every group except the test group then writes the result back to that same address with exactly one `mem_wr` pulse, which falls in the done cycle.
- R10: Register results and flags change only at the end of the done cycle. Up to and including that cycle they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetched opcode byte is offered |
| fetch_byte | input | 8 | The offered opcode byte |
| pc | output | 16 | Program counter |
| mem_addr | output | 16 | Memory address for reads and writes |
| mem_rd | output | 1 | Memory read strobe; data is returned in the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| done | output | 1 | Last cycle of the instruction budget |
| flags | output | 4 | {Z,N,H,C} |
| reg_view | output | 64 | Register file contents, slot i in bits 8i+7:8i |

## Verification
Two events can coincide in the done cycle: the commit of the result and flags, and the offer of a new prefix byte on the fetch input. The bench places a 0xCB byte on the fetch input in exactly that cycle for one instruction in five. It then confirms that no extra memory read follows and that `pc` does not advance a second time, while the commit of that cycle still matches the computed result.

Rotate-through-carry instructions are a second case. They read and replace the carry in the same commit, so sweeping every second-byte value over several register seeds checks the carry consumed against the one produced.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SETB  = 2'd3
  } grp_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  typedef struct packed {
    logic [7:0] val;
    flags_t     fl;
  } bitres_t;

  localparam logic [2:0] MEM_SLOT = 3'd6;
  localparam int         H_SLOT   = 4;
  localparam int         L_SLOT   = 5;

  // Shift-group arithmetic: kind selects one of eight moves.
  function automatic bitres_t shift_op(input logic [2:0] kind,
                                       input logic [7:0] v,
                                       input logic       cin);
    bitres_t o;
    o.val = v;
    o.fl  = '0;
    unique case (kind)
      3'd0: begin o.val = {v[6:0], v[7]}; o.fl.c = v[7]; end
      3'd1: begin o.val = {v[0], v[7:1]}; o.fl.c = v[0]; end
      3'd2: begin o.val = {v[6:0], cin};  o.fl.c = v[7]; end
      3'd3: begin o.val = {cin, v[7:1]};  o.fl.c = v[0]; end
      3'd4: begin o.val = {v[6:0], 1'b0}; o.fl.c = v[7]; end
      3'd5: begin o.val = {v[7], v[7:1]}; o.fl.c = v[0]; end
      3'd6: begin o.val = {v[3:0], v[7:4]}; o.fl.c = 1'b0; end
      default: begin o.val = {1'b0, v[7:1]}; o.fl.c = v[0]; end
    endcase
    o.fl.z = (o.val == 8'h00);
    return o;
  endfunction

  // Whole-group arithmetic: result byte and next flags.
  function automatic bitres_t bit_op(input grp_e       g,
                                     input logic [2:0] idx,
                                     input logic [7:0] v,
                                     input flags_t     fin);
    bitres_t    o;
    logic [7:0] m;
    m     = 8'd1 << idx;
    o.val = v;
    o.fl  = fin;
    unique case (g)
      GRP_SHIFT: o = shift_op(idx, v, fin.c);
      GRP_TEST: begin
        o.fl.z = ~|(v & m);
        o.fl.n = 1'b0;
        o.fl.h = 1'b1;
      end
      GRP_CLR:  o.val = v & ~m;
      default:  o.val = v | m;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import pfx_pkg::*;
(
  input  logic [7:0] code,
  output grp_e       grp,
  output logic [2:0] idx,
  output logic [2:0] sel,
  output logic       is_mem,
  output logic       writes
);
  always_comb begin
    grp    = grp_e'(code[7:6]);
    idx    = code[5:3];
    sel    = code[2:0];
    is_mem = (code[2:0] == MEM_SLOT);
    writes = (grp != GRP_TEST);
  end
endmodule

// File: rtl/pfx_bitunit.sv
module pfx_bitunit
  import pfx_pkg::*;
(
  input  grp_e       grp,
  input  logic [2:0] idx,
  input  logic [7:0] opnd,
  input  flags_t     fl_in,
  output bitres_t    res
);
  always_comb res = bit_op(grp, idx, opnd, fl_in);
endmodule

// File: rtl/pfx_regfile.sv
module pfx_regfile #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [W-1:0]     wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [W-1:0]     rdata,
  output logic [N*W-1:0]   view
);
  logic [W-1:0] ent [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                               ent[gi] <= '0;
      else if (we && (wsel == SEL_W'(gi)))      ent[gi] <= wdata;
    end
    assign view[gi*W +: W] = ent[gi];
  end

  assign rdata = ent[rsel];
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
  import pfx_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          REG_CYC = 8,
  parameter int          MEM_CYC = 16,
  parameter logic [7:0]  PREFIX  = 8'hCB,
  localparam int         CNT_W   = $clog2(MEM_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [7:0]        fetch_byte,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [3:0]        flags,
  output logic [63:0]       reg_view
);
  localparam logic [CNT_W-1:0] REG_LAST = CNT_W'(REG_CYC - 1);
  localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(MEM_CYC - 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] pc_q;
  logic [7:0]        code_q;
  logic [7:0]        opnd_q;
  flags_t            flags_q;

  grp_e       grp;
  logic [2:0] idx, sel;
  logic       is_mem, writes;
  logic [7:0] rf_rdata, opnd;
  bitres_t    res;
  logic [CNT_W-1:0] last_cnt;
  logic [ADDR_W-1:0] hl_addr;

  // Named internal events
  logic accept, fetch_evt, code_evt, opnd_rd_evt, opnd_cap_evt, commit_evt, wb_en;

  pfx_decode u_dec (
    .code(code_q), .grp(grp), .idx(idx), .sel(sel), .is_mem(is_mem), .writes(writes)
  );

  pfx_regfile #(.N(8), .W(8)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(wb_en && !is_mem), .wsel(sel), .wdata(res.val),
    .rsel(sel), .rdata(rf_rdata), .view(reg_view)
  );

  pfx_bitunit u_bu (
    .grp(grp), .idx(idx), .opnd(opnd), .fl_in(flags_q), .res(res)
  );

  assign hl_addr      = ADDR_W'({reg_view[H_SLOT*8 +: 8], reg_view[L_SLOT*8 +: 8]});
  assign last_cnt     = is_mem ? MEM_LAST : REG_LAST;
  assign accept       = !busy_q && fetch_valid && (fetch_byte == PREFIX);
  assign fetch_evt    = busy_q && (cnt_q == '0);
  assign code_evt     = busy_q && (cnt_q == CNT_W'(1));
  assign opnd_rd_evt  = busy_q && is_mem && (cnt_q == CNT_W'(2));
  assign opnd_cap_evt = busy_q && is_mem && (cnt_q == CNT_W'(3));
  assign commit_evt   = busy_q && (cnt_q == last_cnt);
  assign wb_en        = commit_evt && writes;
  assign opnd         = is_mem ? opnd_q : rf_rdata;

  assign mem_rd    = fetch_evt || opnd_rd_evt;
  assign mem_wr    = wb_en && is_mem;
  assign mem_addr  = fetch_evt ? pc_q : hl_addr;
  assign mem_wdata = res.val;
  assign done      = commit_evt;
  assign pc        = pc_q;
  assign flags     = flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      pc_q    <= '0;
      code_q  <= '0;
      opnd_q  <= '0;
      flags_q <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (commit_evt) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
      if (fetch_evt)    pc_q    <= pc_q + ADDR_W'(1);
      if (code_evt)     code_q  <= mem_rdata;
      if (opnd_cap_evt) opnd_q  <= mem_rdata;
      if (commit_evt)   flags_q <= res.fl;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  wr_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> done);
  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> (pc == $past(pc) + ADDR_W'(1)));
  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_evt |=> $stable(pc));
  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(flags));
  // R10
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(reg_view));
  // R6
  test_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && code_q[7:6] == 2'b01) |=> $stable(reg_view));
  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: tb/pfx_seq_bench.sv
module pfx_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [7:0]  fetch_byte = 8'h00;
  logic [15:0] pc, mem_addr;
  logic        mem_rd, mem_wr, done;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [3:0]  flags;
  logic [63:0] reg_view;

  always #2.5 clk = ~clk;

  pfx_seq u_pfx_seq (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .pc(pc), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .flags(flags), .reg_view(reg_view)
  );

  logic [7:0]  dmem [4096];
  logic [7:0]  emem [4096];
  int          wr_cnt = 0, rd_cnt = 0, done_cnt = 0;
  logic [15:0] last_wa = '0;
  logic [7:0]  last_wd = '0;

  always @(posedge clk) begin
    if (mem_rd) begin mem_rdata <= dmem[mem_addr[11:0]]; rd_cnt <= rd_cnt + 1; end
    if (mem_wr) begin
      dmem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt  <= wr_cnt + 1;
      last_wa <= mem_addr;
      last_wd <= mem_wdata;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0]  er [8];
  logic [3:0]  ef = 4'h0;
  logic [15:0] exp_pc = 16'h0;
  bit          ex_wr;
  logic [15:0] ex_wa;
  logic [7:0]  ex_wd;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] packed_regs();
    logic [63:0] p;
    for (int i = 0; i < 8; i++) p[i*8 +: 8] = er[i];
    return p;
  endfunction

  // Independent model of one instruction (R4..R7, R9)
  task automatic model(input logic [7:0] op2);
    int          s, b, g;
    logic [15:0] a;
    logic [7:0]  v, r;
    logic        cin, z, c;
    s = op2[2:0]; b = op2[5:3]; g = op2[7:6];
    a = {er[4], er[5]};
    v = (s == 6) ? emem[a[11:0]] : er[s];
    cin = ef[0];
    r = v; ex_wr = 0; ex_wa = a; ex_wd = 0;
    if (g == 0) begin
      c = 0;
      case (b)
        0: begin r = 8'((v << 1) | (v >> 7)); c = v[7]; end
        1: begin r = 8'((v >> 1) | (v << 7)); c = v[0]; end
        2: begin r = 8'((v << 1) | 8'(cin)); c = v[7]; end
        3: begin r = 8'((v >> 1) | (8'(cin) << 7)); c = v[0]; end
        4: begin r = 8'(v << 1); c = v[7]; end
        5: begin r = (v >> 1) | (v & 8'h80); c = v[0]; end
        6: begin r = 8'((v << 4) | (v >> 4)); c = 0; end
        default: begin r = v >> 1; c = v[0]; end
      endcase
      z = (r == 0);
      ef = {z, 1'b0, 1'b0, c};
    end else if (g == 1) begin
      z = (((v >> b) & 8'h01) == 0);
      ef = {z, 1'b0, 1'b1, ef[0]};
    end else if (g == 2) r = v & ~(8'h01 << b);
    else r = v | (8'h01 << b);
    if (g != 1) begin
      if (s == 6) begin emem[a[11:0]] = r; ex_wr = 1; ex_wd = r; end
      else er[s] = r;
    end
  endtask

  task automatic run(input logic [7:0] op2, input bit poke);
    logic [63:0] pre_view;
    logic [3:0]  pre_fl;
    int budget, w0, r0;
    string ftag;
    dmem[exp_pc[11:0]] = op2;
    emem[exp_pc[11:0]] = op2;
    pre_view = packed_regs();
    pre_fl   = ef;
    budget   = (op2[2:0] == 3'd6) ? 16 : 8;
    ftag     = (op2[7:6] == 0) ? "R5 flags" : (op2[7:6] == 1) ? "R6 flags" : "R7 flags";
    model(op2);
    exp_pc = exp_pc + 16'd1;
    w0 = wr_cnt;
    fetch_valid = 1; fetch_byte = 8'hCB;
    @(negedge clk);
    fetch_valid = 0; fetch_byte = 8'h00;
    for (int k = 1; k <= budget; k++) begin
      if (k < budget) begin
        chk("R8 done early", done, 0);
        @(negedge clk);
      end else begin
        chk("R8 done at budget", done, 1);
        chk("R10 regs before commit", reg_view, pre_view);
        chk("R10 flags before commit", flags, pre_fl);
      end
    end
    if (poke) begin fetch_valid = 1; fetch_byte = 8'hCB; end
    @(negedge clk);
    fetch_valid = 0; fetch_byte = 8'h00;
    chk("R8 done single", done, 0);
    chk("R3 pc", pc, exp_pc);
    chk("R4 regs", reg_view, packed_regs());
    chk(ftag, flags, ef);
    chk("R9 write count", wr_cnt - w0, ex_wr ? 1 : 0);
    if (ex_wr) begin
      chk("R9 write addr", last_wa, ex_wa);
      chk("R9 write data", last_wd, ex_wd);
    end
    if (poke) begin
      r0 = rd_cnt;
      repeat (3) @(negedge clk);
      chk("R2 prefix in done cycle ignored", rd_cnt - r0, 0);
      chk("R2 pc after poke", pc, exp_pc);
    end
  endtask

  task automatic load_reg(input int s, input logic [7:0] v);
    for (int b = 0; b < 8; b++)
      run({v[b] ? 2'b11 : 2'b10, 3'(b), 3'(s)}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      dmem[i] = 8'((i * 7 + 3) ^ (i >> 5));
      emem[i] = dmem[i];
    end
    for (int i = 0; i < 8; i++) er[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 0);
    chk("R1 regs", reg_view, 0);
    chk("R1 flags", flags, 0);
    chk("R1 strobes", {done, mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", {done, mem_rd, mem_wr}, 0);

    // R2: non-prefix bytes leave the block idle
    foreach (fetch_byte[i]) ;
    for (int j = 0; j < 6; j++) begin
      fetch_valid = 1;
      fetch_byte  = 8'((j * 73 + 1) ^ ((j == 2) ? 8'hCA : 8'h00));
      if (fetch_byte == 8'hCB) fetch_byte = 8'hCC;
      @(negedge clk);
    end
    fetch_valid = 0; fetch_byte = 8'h00;
    @(negedge clk);
    chk("R2 no reads for other bytes", rd_cnt, 0);
    chk("R2 pc unchanged", pc, 0);
    chk("R2 no done", done_cnt, 0);

    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 8; s++)
        if (s != 6) load_reg(s, 8'((p * 53 + s * 29 + 17) ^ (p << 6)));
      for (int i = 0; i < 256; i++)
        run(8'(i), (i % 5) == p);
    end
    summary();
  end
endmodule